// File: doc/BRIEF.md
# SPI Shift Port with FIFO Status and Interrupts

This block is the data path of a serial peripheral port. A shift engine clocks frames out on a serial data output and samples a serial data input. Small transmit and receive FIFOs sit between the engine and a 16-bit register bus. The engine runs one frame per byte of a block. Software starts a block by writing the number of frames to a count register. Each frame may carry a full byte or a shorter run of one to seven bits, as set by a receive length field.

Three sticky event flags record a received byte, a transmitted byte and the end of a block. Each flag has its own enable, and the interrupt output is raised when any enabled flag is set. One shared error flag records both transmit underflow and receive overflow. Software tells the two cases apart by reading the FIFO empty and full indications next to the flag. A FIFO reset control bit empties both FIFOs and clears the error flag.

Register map (3-bit address): 0 control, 1 interrupt enable, 2 status, 3 data, 4 frame count.

Top module: `spi_link_core`

## Requirements
- R1: After reset the control register reads 0x0500, meaning only the transmit-empty bit (bit 8) and the receive-empty bit (bit 10) are set. The enable register, the status register, the frame count and `irq` all read 0.
- R2: A length field (control bits [2:0]) of 0 makes each frame 8 bits long. The frame gives 8 rising serial clock edges and stores the whole byte, sent MSB first, in the receive FIFO.
- R3: A length field of N, with N from 1 to 7, makes each frame exactly N bits long. The N received bits are stored right-justified and the upper bits are 0, so with the data output looped back to the input the result is the sent byte shifted right by 8−N.
- R4: Enable bit 2 gates the receive flag, bit 1 the transmit flag and bit 0 the block flag. `irq` is high exactly when some flag and its enable are both 1, and a flag whose enable is 0 can still be read in the status register.
- R5: The status register reads the error flag in bit 7, the receive flag in bit 2, the transmit flag in bit 1 and the block flag in bit 0. Every other bit reads 0.
- R6: Writing 1 to status bits [2:0] clears those flags. An event that falls in the same cycle as such a clear leaves its flag set.
- R7: If a frame starts while the transmit FIFO is empty, the error flag is set and the frame shifts out zeros. A frame that took no byte from the FIFO does not set the transmit flag.
- R8: If a frame completes while the receive FIFO is full and is not being read, the received byte is dropped. The error flag is set, the receive flag is not set, and control bit 11 (receive-full) reads 1.
- R9: Writing 1 to control bit 3 empties both FIFOs and clears the error flag in that cycle. The bit always reads 0.
- R10: Reserved bits are ignored on write and read as 0. Writing 0xFFFF to the enable register reads back 0x0007.
- R11: The transmit flag is set at the end of each frame that took a byte from the transmit FIFO. The block flag is set when the frame count reaches 0.
- R12: Each FIFO holds 4 entries. A data write to a full transmit FIFO is ignored, and control bit 9 (transmit-full) reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of the data address pops the receive FIFO |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from the address |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out, MSB first |
| spi_miso | input | 1 | Serial data in, sampled on the rising serial clock edge |
| irq | output | 1 | Interrupt request |

## Verification
The case that needs the most care is a receive-flag clear by software that lands in the same cycle as the engine finishing a frame and setting that flag. The bench starts a one-frame block with only the receive interrupt enabled. It then writes a receive-flag clear to the status register on every cycle across the whole frame, watching `irq` at each falling clock edge. Because the event wins, `irq` must be seen high for at least one cycle, and the flag must read clear afterwards because of the clears that follow. A second overlap is the FIFO reset arriving while an error is pending: the flag must read 0 at once.

// File: rtl/spi_link_pkg.sv
package spi_link_pkg;
   localparam int REG_W  = 16;
   localparam int ADDR_W = 3;

   localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
   localparam logic [ADDR_W-1:0] A_IE    = 3'd1;
   localparam logic [ADDR_W-1:0] A_STAT  = 3'd2;
   localparam logic [ADDR_W-1:0] A_DATA  = 3'd3;
   localparam logic [ADDR_W-1:0] A_COUNT = 3'd4;

   // control register bit positions
   localparam int C_INIT    = 3;
   localparam int C_TXEMPTY = 8;
   localparam int C_TXFULL  = 9;
   localparam int C_RXEMPTY = 10;
   localparam int C_RXFULL  = 11;

   // status register bit positions
   localparam int S_ERR = 7;

   // event flag indices (shared by enable and status)
   localparam int N_EVT   = 3;
   localparam int EV_BLK  = 0;
   localparam int EV_TX   = 1;
   localparam int EV_RX   = 2;
endpackage

// File: rtl/spi_link_fifo.sv
module spi_link_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             empty,
   output logic             full
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [AW:0] DEPTH_C = (AW+1)'(DEPTH);

   initial begin
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("spi_link_fifo: DEPTH must be a power of two >= 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wp_q, rp_q;
   logic [AW:0]      cnt_q;
   logic             do_push, do_pop;

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == DEPTH_C);
   assign do_pop  = pop && !empty;
   assign do_push = push && (!full || do_pop);
   assign dout    = empty ? '0 : mem[rp_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else if (clr) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wp_q <= wp_q + 1'b1;
         if (do_pop)  rp_q <= rp_q + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !clr) mem[wp_q] <= din;
   end

   // R12: a push into a full FIFO with no pop leaves the fill level unchanged
   a_r12_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !clr) |=> $stable(cnt_q));

   // R9: clear leaves the FIFO empty
   a_r9_clr_empties: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> empty);
endmodule

// File: rtl/spi_link_shifter.sv
module spi_link_shifter #(
   parameter int DATA_W   = 8,
   parameter int HALF_DIV = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start,
   input  logic                        tx_valid,
   input  logic [DATA_W-1:0]           tx_byte,
   input  logic [$clog2(DATA_W)-1:0]   len,
   input  logic                        miso,
   output logic                        sclk,
   output logic                        mosi,
   output logic                        busy,
   output logic                        done,
   output logic [DATA_W-1:0]           rx_byte,
   output logic                        tx_used
);
   localparam int LEN_W = $clog2(DATA_W);
   localparam int DIV_W = $clog2(HALF_DIV);
   localparam logic [LEN_W:0]   FULL_LEN = (LEN_W+1)'(DATA_W);
   localparam logic [DIV_W-1:0] DIV_TOP  = DIV_W'(HALF_DIV - 1);

   initial begin
      assert (HALF_DIV >= 2) else $error("spi_link_shifter: HALF_DIV must be >= 2");
      assert (DATA_W >= 2 && (DATA_W & (DATA_W - 1)) == 0)
         else $error("spi_link_shifter: DATA_W must be a power of two");
   end

   logic [DIV_W-1:0]  div_q;
   logic [DATA_W-1:0] txsh_q, rxsh_q;
   logic [LEN_W:0]    left_q, len_q, eff_len;
   logic              sclk_q, busy_q, used_q, tick;

   assign eff_len = (len == '0) ? FULL_LEN : {1'b0, len};
   assign tick    = busy_q && (div_q == DIV_TOP);
   assign done    = tick && sclk_q && (left_q == {{LEN_W{1'b0}}, 1'b1});
   assign sclk    = sclk_q;
   assign mosi    = busy_q & txsh_q[DATA_W-1];
   assign busy    = busy_q;
   assign rx_byte = rxsh_q;
   assign tx_used = used_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q  <= '0;
         sclk_q <= 1'b0;
         busy_q <= 1'b0;
         used_q <= 1'b0;
         txsh_q <= '0;
         rxsh_q <= '0;
         left_q <= '0;
         len_q  <= '0;
      end else if (start && !busy_q) begin
         busy_q <= 1'b1;
         used_q <= tx_valid;
         txsh_q <= tx_valid ? tx_byte : '0;
         rxsh_q <= '0;
         left_q <= eff_len;
         len_q  <= eff_len;
         div_q  <= '0;
         sclk_q <= 1'b0;
      end else if (busy_q) begin
         if (tick) begin
            div_q  <= '0;
            sclk_q <= ~sclk_q;
            if (!sclk_q) begin
               rxsh_q <= {rxsh_q[DATA_W-2:0], miso};
            end else begin
               txsh_q <= {txsh_q[DATA_W-2:0], 1'b0};
               left_q <= left_q - 1'b1;
               if (left_q == {{LEN_W{1'b0}}, 1'b1}) busy_q <= 1'b0;
            end
         end else begin
            div_q <= div_q + 1'b1;
         end
      end
   end

   // independent count of rising serial clock edges within the frame
   logic [LEN_W:0] rise_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   rise_q <= '0;
      else if (start && !busy_q)    rise_q <= '0;
      else if (tick && !sclk_q)     rise_q <= rise_q + 1'b1;
   end

   // R2 / R3: a frame ends after exactly the programmed number of rising edges
   a_r3_edge_count: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (rise_q == len_q));

   // R2: serial clock idles low between frames
   a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> !sclk_q);
endmodule

// File: rtl/spi_link_irq.sv
module spi_link_irq #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] evt,
   input  logic [N-1:0] w1c,
   input  logic [N-1:0] en,
   output logic [N-1:0] flags,
   output logic         irq
);
   logic [N-1:0] pend;

   for (genvar i = 0; i < N; i++) begin : g_flag
      logic f_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      f_q <= 1'b0;
         else if (evt[i]) f_q <= 1'b1;
         else if (w1c[i]) f_q <= 1'b0;
      end
      assign flags[i] = f_q;
      assign pend[i]  = f_q & en[i];

      // R6: an event in the same cycle as a clear leaves the flag set
      a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         evt[i] |=> f_q);
   end

   assign irq = |pend;

   // R4: no enables, no interrupt
   a_r4_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (en == '0) |-> !irq);
endmodule

// File: rtl/spi_link_core.sv
module spi_link_core
   import spi_link_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int FIFO_DEPTH = 4,
   parameter int HALF_DIV   = 2,
   parameter int BLK_W      = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   output logic              spi_sclk,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic              irq
);
   localparam int LEN_W = $clog2(DATA_W);

   initial begin
      assert (DATA_W <= 8 && LEN_W <= C_INIT)
         else $error("spi_link_core: length field must fit below the init bit");
      assert (BLK_W <= REG_W) else $error("spi_link_core: BLK_W exceeds bus width");
   end

   // register decode
   logic wr_ctrl, wr_ie, wr_stat, wr_data, wr_cnt, rd_data, init_p;
   assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
   assign wr_ie   = reg_wr && (reg_addr == A_IE);
   assign wr_stat = reg_wr && (reg_addr == A_STAT);
   assign wr_data = reg_wr && (reg_addr == A_DATA);
   assign wr_cnt  = reg_wr && (reg_addr == A_COUNT);
   assign rd_data = reg_rd && (reg_addr == A_DATA);
   assign init_p  = wr_ctrl && reg_wdata[C_INIT];

   logic [LEN_W-1:0] len_q;
   logic [N_EVT-1:0] ie_q;
   logic [BLK_W-1:0] remain_q;
   logic             err_q;

   // FIFOs
   logic [DATA_W-1:0] tx_dout, rx_dout, sh_rx;
   logic tx_empty, tx_full, rx_empty, rx_full;
   logic sh_start, sh_busy, sh_done, sh_used, tx_pop;

   assign sh_start = !sh_busy && (remain_q != '0);
   assign tx_pop   = sh_start && !tx_empty;

   spi_link_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_txf (
      .clk(clk), .rst_n(rst_n), .clr(init_p),
      .push(wr_data), .din(reg_wdata[DATA_W-1:0]),
      .pop(tx_pop), .dout(tx_dout), .empty(tx_empty), .full(tx_full));

   logic rx_drop, rx_store;
   assign rx_drop  = sh_done && rx_full && !rd_data;
   assign rx_store = sh_done && !rx_drop;

   spi_link_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxf (
      .clk(clk), .rst_n(rst_n), .clr(init_p),
      .push(rx_store), .din(sh_rx),
      .pop(rd_data), .dout(rx_dout), .empty(rx_empty), .full(rx_full));

   spi_link_shifter #(.DATA_W(DATA_W), .HALF_DIV(HALF_DIV)) u_sh (
      .clk(clk), .rst_n(rst_n), .start(sh_start),
      .tx_valid(!tx_empty), .tx_byte(tx_dout), .len(len_q),
      .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi),
      .busy(sh_busy), .done(sh_done), .rx_byte(sh_rx), .tx_used(sh_used));

   // events
   logic [N_EVT-1:0] evt, w1c, flags;
   logic underflow, last_frame;
   assign underflow  = sh_start && tx_empty;
   assign last_frame = sh_done && (remain_q == {{(BLK_W-1){1'b0}}, 1'b1});

   always_comb begin
      evt         = '0;
      evt[EV_RX]  = rx_store;
      evt[EV_TX]  = sh_done && sh_used;
      evt[EV_BLK] = last_frame;
      w1c         = wr_stat ? reg_wdata[N_EVT-1:0] : '0;
   end

   spi_link_irq #(.N(N_EVT)) u_irq (
      .clk(clk), .rst_n(rst_n), .evt(evt), .w1c(w1c), .en(ie_q),
      .flags(flags), .irq(irq));

   // registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q    <= '0;
         ie_q     <= '0;
         remain_q <= '0;
         err_q    <= 1'b0;
      end else begin
         if (wr_ctrl) len_q <= reg_wdata[LEN_W-1:0];
         if (wr_ie)   ie_q  <= reg_wdata[N_EVT-1:0];
         if (wr_cnt)       remain_q <= reg_wdata[BLK_W-1:0];
         else if (sh_done) remain_q <= remain_q - 1'b1;
         if (init_p)                     err_q <= 1'b0;
         else if (underflow || rx_drop)  err_q <= 1'b1;
      end
   end

   // read mux
   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_CTRL: begin
            reg_rdata[LEN_W-1:0] = len_q;
            reg_rdata[C_TXEMPTY] = tx_empty;
            reg_rdata[C_TXFULL]  = tx_full;
            reg_rdata[C_RXEMPTY] = rx_empty;
            reg_rdata[C_RXFULL]  = rx_full;
         end
         A_IE:    reg_rdata[N_EVT-1:0]  = ie_q;
         A_STAT: begin
            reg_rdata[N_EVT-1:0] = flags;
            reg_rdata[S_ERR]     = err_q;
         end
         A_DATA:  reg_rdata[DATA_W-1:0] = rx_dout;
         A_COUNT: reg_rdata[BLK_W-1:0]  = remain_q;
         default: reg_rdata = '0;
      endcase
   end

   // R9: FIFO reset clears the error flag in the same cycle
   a_r9_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
      init_p |=> !err_q);

   // R7: a frame started on an empty transmit FIFO raises the error flag
   a_r7_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      (underflow && !init_p) |=> err_q);

   // R8: a dropped byte raises the error flag and not the receive flag
   a_r8_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_drop && !init_p) |=> err_q);

   // R11: the block flag follows the count reaching zero
   a_r11_block_end: assert property (@(posedge clk) disable iff (!rst_n)
      (last_frame && !wr_cnt) |=> (flags[EV_BLK] && remain_q == '0));
endmodule

// File: tb/spi_link_core_tb_top.sv
module spi_link_core_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        spi_sclk, spi_mosi, irq;

   always #5 clk = ~clk;

   spi_link_core dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_mosi), .irq(irq));

   localparam logic [2:0] CTRL = 0, IE = 1, STAT = 2, DATA = 3, COUNT = 4;

   int n_tests = 0, n_fail = 0;
   int rise_n = 0;
   logic [7:0] exp_q[$];

   always @(posedge spi_sclk) rise_n = rise_n + 1;

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   // driver: push a byte and the value the receive side must return
   task automatic send(input logic [7:0] b, input int len);
      wr(DATA, {8'h00, b});
      exp_q.push_back(len == 0 ? b : (b >> (8 - len)));
   endtask

   task automatic wait_idle();
      logic [15:0] v;
      for (int i = 0; i < 2000; i++) begin
         rd(COUNT, v);
         if (v == 0) break;
      end
      repeat (3) @(negedge clk);
   endtask

   // monitor side: pop the receive FIFO and compare with the scoreboard
   task automatic pop_chk(input string tag);
      logic [15:0] v;
      logic [7:0]  e;
      rd(DATA, v);
      reg_rd = 1'b1;
      @(negedge clk);
      reg_rd = 1'b0;
      e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
      chk(tag, v, {8'h00, e});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [15:0] v;
      int base;
      bit seen;
      logic [7:0] bytes [3];
      int lens [3];
      bytes[0] = 8'h80; bytes[1] = 8'hD7; bytes[2] = 8'h81;
      lens[0]  = 1;     lens[1]  = 3;     lens[2]  = 7;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(CTRL, v);  chk("R1 ctrl", v, 16'h0500);
      rd(IE, v);    chk("R1 ie", v, 16'h0000);
      rd(STAT, v);  chk("R1 stat", v, 16'h0000);
      rd(COUNT, v); chk("R1 count", v, 16'h0000);
      chk("R1 irq", {15'h0, irq}, 16'h0000);

      // R10 reserved bits
      wr(IE, 16'hFFFF); rd(IE, v); chk("R10 ie readback", v, 16'h0007);
      wr(IE, 16'h0000);
      wr(CTRL, 16'hFFF7); rd(CTRL, v); chk("R10 ctrl readback", v, 16'h0507);
      wr(CTRL, 16'h0000);

      // R2 full byte frames, R11 flags, R5 layout
      send(8'hA5, 0); send(8'h3C, 0);
      base = rise_n;
      wr(COUNT, 16'd2);
      wait_idle();
      chk("R2 rising edges", 16'(rise_n - base), 16'd16);
      rd(STAT, v); chk("R11 R5 flags after block", v, 16'h0007);
      pop_chk("R2 byte 0"); pop_chk("R2 byte 1");
      rd(CTRL, v); chk("R2 rx empty after reads", v, 16'h0500);

      // R4 enable gating
      chk("R4 irq with no enables", {15'h0, irq}, 16'h0000);
      wr(IE, 16'h0001); @(negedge clk);
      chk("R4 irq on block enable", {15'h0, irq}, 16'h0001);
      wr(STAT, 16'h0001); rd(STAT, v);
      chk("R6 w1c block flag", v, 16'h0006);
      chk("R4 irq after clear", {15'h0, irq}, 16'h0000);
      wr(IE, 16'h0006); @(negedge clk);
      chk("R4 irq on rx/tx enables", {15'h0, irq}, 16'h0001);
      wr(STAT, 16'h0006); rd(STAT, v);
      chk("R6 w1c rx tx", v, 16'h0000);
      chk("R4 irq all clear", {15'h0, irq}, 16'h0000);
      wr(IE, 16'h0000);

      // R3 partial frames
      for (int k = 0; k < 3; k++) begin
         wr(CTRL, 16'(lens[k]));
         rd(CTRL, v); chk("R3 length readback", v, 16'h0500 | 16'(lens[k]));
         send(bytes[k], lens[k]);
         base = rise_n;
         wr(COUNT, 16'd1);
         wait_idle();
         chk("R3 rising edges", 16'(rise_n - base), 16'(lens[k]));
         pop_chk("R3 right-justified data");
      end
      wr(CTRL, 16'h0000);
      wr(STAT, 16'h0007);

      // R12 transmit FIFO depth
      send(8'h11, 0); send(8'h22, 0); send(8'h33, 0); send(8'h44, 0);
      wr(DATA, 16'h0055);
      rd(CTRL, v); chk("R12 tx full", v, 16'h0600);
      wr(COUNT, 16'd4);
      wait_idle();
      rd(CTRL, v); chk("R12 tx drained rx full", v, 16'h0900);
      rd(STAT, v); chk("R12 fifth write ignored no error", v & 16'h0080, 16'h0000);

      // R8 receive overflow
      wr(DATA, 16'h0099);
      wr(COUNT, 16'd1);
      wait_idle();
      rd(STAT, v); chk("R8 error set", v & 16'h0080, 16'h0080);
      rd(CTRL, v); chk("R8 rx full tx empty", v, 16'h0900);
      pop_chk("R8 kept 0"); pop_chk("R8 kept 1"); pop_chk("R8 kept 2"); pop_chk("R8 kept 3");
      rd(CTRL, v); chk("R8 dropped byte absent", v, 16'h0500);

      // R9 FIFO reset
      wr(DATA, 16'h0012); wr(DATA, 16'h0034);
      wr(CTRL, 16'h0008);
      rd(STAT, v); chk("R9 error cleared", v & 16'h0080, 16'h0000);
      rd(CTRL, v); chk("R9 fifos empty, bit reads 0", v, 16'h0500);

      // R7 transmit underflow
      wr(STAT, 16'h0007);
      exp_q.push_back(8'h00);
      wr(COUNT, 16'd1);
      wait_idle();
      rd(STAT, v); chk("R7 error, rx and block only", v, 16'h0085);
      rd(CTRL, v); chk("R7 tx empty visible", v, 16'h0100);
      pop_chk("R7 zeros shifted");
      wr(CTRL, 16'h0008);

      // R6 clear and event in the same cycle
      wr(STAT, 16'h0007);
      wr(IE, 16'h0004);
      send(8'h5A, 0);
      wr(COUNT, 16'd1);
      seen = 1'b0;
      for (int i = 0; i < 80; i++) begin
         @(negedge clk);
         if (irq) seen = 1'b1;
         reg_wr = 1'b1; reg_addr = STAT; reg_wdata = 16'h0004;
      end
      @(negedge clk);
      reg_wr = 1'b0;
      chk("R6 event wins over clear", {15'h0, seen}, 16'h0001);
      rd(STAT, v); chk("R6 later clear took effect", v, 16'h0003);
      pop_chk("R6 byte stored");

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule